// File: doc/BRIEF.md
# DDR burst column address sequencer

This block holds the base mode word of a DDR memory device and expands each READ or WRITE command into the column addresses of its burst. The mode word is captured from an address bus whenever a load strobe arrives with both bank-select bits low. The word sets the burst length, the ordering (sequential or interleaved) and the read latency field. The latency field is only stored and reported, because the data path applies the latency.

When a command arrives, the starting column splits into two parts. The upper bits pick an aligned block whose size is the burst length. The lower bits give the first beat inside that block. The sequencer then issues one column address per clock and wraps inside the block. If a mode word holds a reserved code, the block raises an error flag and refuses commands until a legal word is loaded.

Top module: `ddr_burst_seq`

## Requirements
- R1: Mode bits 2:0 set the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. Every other code is reserved.
- R2: When mode bit 3 is 0 (sequential), beat k uses offset (s + k) mod L, where s is the column address masked to its low log2(L) bits.
- R3: When mode bit 3 is 1 (interleaved), beat k uses offset s XOR k. In both orders, the column bits above the low log2(L) bits keep the values they had in the command.
- R4: A mode load with mode_ba other than 2'b00 leaves the stored settings, mode_err and rd_lat unchanged.
- R5: An accepted command gives L consecutive cycles of beat_vld, starting the cycle after acceptance. beat_last is high only on the final beat, and beat_wr equals the command's cmd_wr for every beat of the burst.
- R6: The following codes are reserved and raise mode_err: a reserved burst length; a latency field (bits 6:4) other than 3'b010 (2 clocks) or 3'b110 (2.5 clocks); an operating field (bits 12:7) other than 6'b000000 or 6'b000010. While mode_err is set, commands produce no beats. A later legal load clears mode_err and re-enables bursts.
- R7: rd_lat shows bits 6:4 of the last base mode load.
- R8: A command is accepted only while the sequencer is idle or during the cycle that shows the last beat. A command presented during any other beat is ignored.
- R9: After reset beat_vld, mode_err and rd_lat are 0, and commands produce no beats until a legal mode word has been loaded.
- R10: A command accepted in the same cycle as a mode load uses the settings that were in force before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ld | input | 1 | Mode-load strobe |
| mode_ba | input | 2 | Bank-select bits of the load; 00 selects the base mode word |
| mode_addr | input | ADDR_W | Mode word on the address bus |
| cmd_vld | input | 1 | Read/write command strobe |
| cmd_wr | input | 1 | 1 for write, 0 for read |
| cmd_col | input | COL_W | Starting column address |
| beat_vld | output | 1 | A beat address is present |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| beat_wr | output | 1 | Read/write flag of the current burst |
| mode_err | output | 1 | Last base mode load held a reserved code |
| rd_lat | output | 3 | Stored read latency field |

## Verification
Two events can land in the same cycle: a mode load arriving together with the acceptance of a command, and a new command arriving during the beat that ends the previous burst. The bench provokes the first by loading an 8-beat mode while a command is issued under a 2-beat mode. Its scoreboard expects exactly two beats, followed by eight beats for the next command. The bench provokes the second by placing a command in the cycle that shows beat_last. It then expects the beats of the new burst to follow with no idle gap, and any extra or missing beat counts as a mismatch.

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq #(
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [1:0]        mode_ba,
  input  logic [ADDR_W-1:0] mode_addr,
  input  logic              cmd_vld,
  input  logic              cmd_wr,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              beat_vld,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_last,
  output logic              beat_wr,
  output logic              mode_err,
  output logic [2:0]        rd_lat
);
  localparam int OFS_W = 3;
  localparam logic [5:0] OP_DLL = 6'b000010;

  logic             mode_ok, err_q, intl_cfg, intl_q, wr_q, act;
  logic [2:0]       len_cfg, lat_q, cnt, mask_q, cfg_mask, s, off;
  logic [COL_W-1:0] col_q;

  wire       ld_base = mode_ld && (mode_ba == 2'b00);
  wire [2:0] f_len   = mode_addr[2:0];
  wire [2:0] f_lat   = mode_addr[6:4];
  wire [5:0] f_op    = mode_addr[12:7];
  wire       len_ok  = (f_len == 3'b001) || (f_len == 3'b010) || (f_len == 3'b011);
  wire       lat_ok  = (f_lat == 3'b010) || (f_lat == 3'b110);
  wire       op_ok   = (f_op == 6'b0) || (f_op == OP_DLL);
  wire       ld_ok   = len_ok && lat_ok && op_ok;

  always_comb begin
    case (len_cfg)
      3'b001:  cfg_mask = 3'b001;
      3'b010:  cfg_mask = 3'b011;
      default: cfg_mask = 3'b111;
    endcase
  end

  assign beat_last = act && (cnt == mask_q);
  wire   accept    = cmd_vld && mode_ok && (!act || beat_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_ok  <= 1'b0;
      err_q    <= 1'b0;
      lat_q    <= '0;
      len_cfg  <= '0;
      intl_cfg <= 1'b0;
    end else if (ld_base) begin
      mode_ok  <= ld_ok;
      err_q    <= !ld_ok;
      lat_q    <= f_lat;
      len_cfg  <= f_len;
      intl_cfg <= mode_addr[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      cnt    <= '0;
      mask_q <= '0;
      intl_q <= 1'b0;
      wr_q   <= 1'b0;
      col_q  <= '0;
    end else if (accept) begin
      act    <= 1'b1;
      cnt    <= '0;
      mask_q <= cfg_mask;
      intl_q <= intl_cfg;
      wr_q   <= cmd_wr;
      col_q  <= cmd_col;
    end else if (beat_last) begin
      act <= 1'b0;
    end else if (act) begin
      cnt <= cnt + 3'd1;
    end
  end

  assign s   = col_q[OFS_W-1:0] & mask_q;
  assign off = intl_q ? (s ^ cnt) : ((s + cnt) & mask_q);

  assign beat_vld = act;
  assign beat_wr  = wr_q;
  assign beat_col = {col_q[COL_W-1:OFS_W], (col_q[OFS_W-1:0] & ~mask_q) | (off & mask_q)};
  assign mode_err = err_q;
  assign rd_lat   = lat_q;
endmodule

module ddr_burst_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_ld,
  input logic [1:0]       mode_ba,
  input logic             beat_vld,
  input logic             beat_last,
  input logic             beat_wr,
  input logic [COL_W-1:0] beat_col,
  input logic             mode_err,
  input logic [2:0]       rd_lat
);
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_vld); // R5
  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_last) |=> (beat_vld && $stable(beat_wr))); // R5
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_last) |=> $stable(beat_col[COL_W-1:3])); // R3
  AST_OTHER_BANK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ld || mode_ba != 2'b00) |=> ($stable(mode_err) && $stable(rd_lat))); // R4
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !beat_vld) |=> !beat_vld); // R6
endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_ba(mode_ba),
  .beat_vld(beat_vld), .beat_last(beat_last), .beat_wr(beat_wr),
  .beat_col(beat_col), .mode_err(mode_err), .rd_lat(rd_lat)
);

// File: tb/tb_ddr_burst_seq.sv
`timescale 1ns/1ps
module tb_ddr_burst_seq;
  localparam int COL_W = 10;

  logic clk = 0, rst_n = 0;
  logic mode_ld = 0, cmd_vld = 0, cmd_wr = 0;
  logic [1:0] mode_ba = 0;
  logic [12:0] mode_addr = 0;
  logic [COL_W-1:0] cmd_col = 0;
  logic beat_vld, beat_last, beat_wr, mode_err;
  logic [COL_W-1:0] beat_col;
  logic [2:0] rd_lat;

  int n_cmp = 0, n_bad = 0;
  logic [COL_W+1:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr_burst_seq #(.COL_W(COL_W), .ADDR_W(13)) dut (.*);

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] c, int len, bit intl, int k);
    logic [2:0] m, s, o;
    m = 3'(len - 1);
    s = c[2:0] & m;
    o = intl ? (s ^ 3'(k)) : ((s + 3'(k)) & m);
    return {c[COL_W-1:3], (c[2:0] & ~m) | (o & m)};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push_burst(logic [COL_W-1:0] c, int len, bit intl, bit wr, string tag);
    for (int k = 0; k < len; k++) begin
      exp_q.push_back({wr, (k == len - 1), exp_col(c, len, intl, k)});
      tag_q.push_back(tag);
    end
  endtask

  function automatic logic [12:0] mword(logic [5:0] op, logic [2:0] lat, bit bt, logic [2:0] bl);
    return {op, lat, bt, bl};
  endfunction

  // caller sits at a negedge
  task automatic load(logic [1:0] ba, logic [12:0] w);
    mode_ld = 1; mode_ba = ba; mode_addr = w;
    @(negedge clk);
    mode_ld = 0; mode_ba = 0;
  endtask

  task automatic cmd(logic [COL_W-1:0] c, bit wr);
    cmd_vld = 1; cmd_col = c; cmd_wr = wr;
    @(negedge clk);
    cmd_vld = 0;
  endtask

  task automatic drain(string tag);
    int lim = 0;
    while ((exp_q.size() != 0 || beat_vld) && lim < 40) begin
      @(negedge clk); lim++;
    end
    @(negedge clk);
    check(exp_q.size() == 0 && !beat_vld, tag, "burst drained", exp_q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && beat_vld) begin
      if (exp_q.size() == 0) begin
        check(0, "R8", "unexpected beat", beat_col, 0);
      end else begin
        logic [COL_W+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({beat_wr, beat_last, beat_col} == e, t, "beat {wr,last,col}",
              {beat_wr, beat_last, beat_col}, e);
      end
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      check(0, "R5", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!beat_vld && !mode_err && rd_lat == 0, "R9", "reset state",
          {beat_vld, mode_err, rd_lat}, 0);
    rst_n = 1;
    @(negedge clk);
    cmd(10'h055, 0);                         // R9: no mode yet, no beats
    drain("R9");

    load(2'b00, mword(6'b0, 3'b010, 0, 3'b010));  // BL4 sequential, latency 2
    check(rd_lat == 3'b010 && !mode_err, "R7", "rd_lat after load", rd_lat, 2);
    push_burst(10'h02D, 4, 0, 0, "R2");
    cmd(10'h02D, 0);
    drain("R2");

    load(2'b00, mword(6'b000010, 3'b110, 1, 3'b011)); // BL8 interleaved, 2.5, DLL reset
    check(rd_lat == 3'b110 && !mode_err, "R7", "rd_lat 2.5 code", rd_lat, 6);
    push_burst(10'h1B5, 8, 1, 1, "R3");
    cmd(10'h1B5, 1);
    drain("R3");

    load(2'b00, mword(6'b0, 3'b010, 0, 3'b001));  // BL2 sequential
    push_burst(10'h3FF, 2, 0, 1, "R1");
    cmd(10'h3FF, 1);
    drain("R1");

    load(2'b00, mword(6'b0, 3'b010, 1, 3'b010));  // BL4 interleaved
    push_burst(10'h012, 4, 1, 0, "R8");
    cmd(10'h012, 0);
    repeat (3) @(negedge clk);               // now in the last-beat cycle
    push_burst(10'h0A7, 4, 1, 1, "R8");
    cmd(10'h0A7, 1);
    drain("R8");

    push_burst(10'h100, 4, 1, 0, "R8");
    cmd(10'h100, 0);
    cmd(10'h2F3, 1);                          // mid-burst: ignored
    drain("R8");

    load(2'b01, mword(6'b111111, 3'b000, 0, 3'b111)); // R4: other bank
    check(!mode_err && rd_lat == 3'b010, "R4", "other bank ignored", {mode_err, rd_lat}, 2);
    push_burst(10'h0C6, 4, 1, 0, "R4");
    cmd(10'h0C6, 0);
    drain("R4");

    load(2'b00, mword(6'b0, 3'b010, 0, 3'b100));  // reserved length
    check(mode_err == 1, "R6", "reserved length flagged", mode_err, 1);
    cmd(10'h010, 0);
    drain("R6");
    load(2'b00, mword(6'b0, 3'b011, 0, 3'b010));  // reserved latency
    check(mode_err == 1, "R6", "reserved latency flagged", mode_err, 1);
    load(2'b00, mword(6'b000001, 3'b010, 0, 3'b010)); // reserved operating field
    check(mode_err == 1, "R6", "reserved op field flagged", mode_err, 1);
    cmd(10'h020, 1);
    drain("R6");

    load(2'b00, mword(6'b0, 3'b010, 0, 3'b001));  // legal BL2 clears error
    check(mode_err == 0, "R6", "legal load clears error", mode_err, 0);

    // R10: load BL8 and command in the same cycle -> old BL2 applies
    push_burst(10'h13B, 2, 0, 0, "R10");
    mode_ld = 1; mode_ba = 0; mode_addr = mword(6'b0, 3'b010, 0, 3'b011);
    cmd(10'h13B, 0);
    mode_ld = 0;
    drain("R10");
    push_burst(10'h13B, 8, 0, 1, "R10");
    cmd(10'h13B, 1);
    drain("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule